// File: doc/BRIEF.md
# Zero-Crossing Gated Stereo Attenuator

This block scales a stream of signed stereo audio samples by a host-selected attenuation and can mute them. A gain step applied in the middle of a waveform leaves a visible step in the signal and an audible click. To avoid this, the block does not apply a new setting at once. It holds each new setting pending until the channel's waveform crosses zero, and then switches.

The host presents a new attenuation step count and a mute flag with a one-cycle load strobe. Both channels take the request. Each channel then waits on its own for a zero crossing. If a channel sees no crossing within a fixed number of input samples, it applies the change anyway, so a DC-like or very low-frequency signal cannot block a volume change.

Samples arrive with a valid strobe and leave one clock later, scaled by the gain in effect for that sample.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset, out_valid, out_left and out_right are 0, no change is pending, and the active setting is 0 dB unmuted, so the first samples pass through unchanged.
- R2: out_valid is high in the cycle after each cycle in which in_valid is high, and low otherwise. out_left and out_right are updated together with it.
- R3: Attenuation is an unsigned count of 0.5 dB steps, with a = 12*q + k and 0 <= k < 12. The output is (x * M[k]) >>> (16 + q), using an arithmetic shift and keeping the low 16 bits. M is: 65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792.
- R4: A pending setting is applied to the first valid sample that is a zero crossing, and that sample is itself scaled by the new setting. A sample is a zero crossing when it equals 0, or when its sign bit differs from the sign bit of the channel's previous valid sample. Before any sample has arrived, the previous sign is taken as non-negative.
- R5: If no zero crossing occurs, a pending setting is applied to the 1024th valid sample after the request, and that sample is scaled by it.
- R6: A load that arrives while a change is pending replaces the pending setting and restarts the 1024-sample count.
- R7: When mute is set, the outputs are 0 once the change takes effect, and this change waits for a zero crossing in the same way. A later unmute takes effect the same way and restores the attenuation written with it.
- R8: The left and right channels detect crossings, count timeouts and apply settings independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe for in_left/in_right |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| tgt_load | input | 1 | One-cycle strobe that requests a new setting |
| tgt_atten | input | 8 | Requested attenuation, in 0.5 dB steps |
| tgt_mute | input | 1 | Requested mute |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |

## Verification
Directed runs do the following:
- Hold one sign across many samples to show that a request stays pending, then cross zero with a sign change or an exact zero sample to show which sample the switch lands on.
- Feed 1023 and then 1024 same-sign samples to separate the timeout boundary from an early or late apply.
- Reload mid-wait to show that the count restarts.
- Drive a crossing on only one channel to show that the channels are independent.
- Step mute on and off.

A seeded random phase mixes sign runs of random length with random attenuation and mute loads, and so covers the scaling table across many step counts.

// File: rtl/zc_gain_pkg.sv
// Package: shared constants and gain mantissa for the zero-crossing attenuator.
// Assumes 12 steps of 0.5 dB per 6 dB octave; mantissas are Q16 unsigned.
package zc_gain_pkg;
    localparam int MANT_FRAC     = 16;
    localparam int MANT_W        = 17;
    localparam int STEPS_PER_OCT = 12;
    localparam int NUM_CH        = 2;

    // Fractional gain for a step position within one octave, 10^(-k/40) in Q16.
    function automatic logic [MANT_W-1:0] step_mantissa(input logic [3:0] idx);
        logic [MANT_W-1:0] m;
        case (idx)
            4'd0:    m = 17'd65536;
            4'd1:    m = 17'd61870;
            4'd2:    m = 17'd58409;
            4'd3:    m = 17'd55142;
            4'd4:    m = 17'd52057;
            4'd5:    m = 17'd49145;
            4'd6:    m = 17'd46396;
            4'd7:    m = 17'd43801;
            4'd8:    m = 17'd41350;
            4'd9:    m = 17'd39037;
            4'd10:   m = 17'd36854;
            default: m = 17'd34792;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/zc_detect.sv
// Module: zero-crossing detector for one channel.
// Reports a crossing on a valid sample that equals zero or whose sign
// differs from the previous valid sample. Assumes the previous sign resets
// to non-negative. Only valid samples update the remembered sign.
module zc_detect #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                zc
);
    logic prev_neg_q;

    // Crossing decision for the sample on the input this cycle.
    always_comb begin
        zc = valid && ((sample[SAMPLE_W-1] != prev_neg_q) || (sample == '0));
    end

    // Remember the sign of the last accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_neg_q <= 1'b0;
        else if (valid)
            prev_neg_q <= sample[SAMPLE_W-1];
    end

    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> prev_neg_q == $past(sample[SAMPLE_W-1])); // R4
endmodule

// File: rtl/zc_chan_ctrl.sv
// Module: per-channel pending-setting controller.
// Holds the active attenuation/mute and one pending request. The pending
// request is applied on a zero crossing or on the TIMEOUT-th valid sample
// after the request. A load in the same cycle as a sample lets that sample
// use the old pending state; the load then replaces it.
module zc_chan_ctrl #(
    parameter int ATTEN_W = 8,
    parameter int TIMEOUT = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ATTEN_W-1:0] tgt_atten,
    input  logic               tgt_mute,
    input  logic               valid,
    input  logic               zc,
    output logic [ATTEN_W-1:0] eff_atten,
    output logic               eff_mute
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    logic [ATTEN_W-1:0] cur_atten_q, pend_atten_q;
    logic               cur_mute_q, pend_mute_q;
    logic               pend_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               apply;

    // Decide whether this sample switches to the pending setting.
    always_comb begin
        apply     = valid && pend_q && (zc || (cnt_q == LAST));
        eff_atten = apply ? pend_atten_q : cur_atten_q;
        eff_mute  = apply ? pend_mute_q  : cur_mute_q;
    end

    // Active setting: takes the pending one when it is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_atten_q <= '0;
            cur_mute_q  <= 1'b0;
        end else if (apply) begin
            cur_atten_q <= pend_atten_q;
            cur_mute_q  <= pend_mute_q;
        end
    end

    // Pending request, its value and its timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_atten_q <= '0;
            pend_mute_q  <= 1'b0;
            cnt_q        <= '0;
        end else if (load) begin
            pend_q       <= 1'b1;
            pend_atten_q <= tgt_atten;
            pend_mute_q  <= tgt_mute;
            cnt_q        <= '0;
        end else if (apply) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (valid && pend_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_LOAD_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pend_q && (cnt_q == '0)); // R6
    AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |-> (cnt_q == '0)); // R5
    AST_TIMEOUT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && pend_q && (cnt_q == LAST) && !load)
        |=> !pend_q && (cur_atten_q == $past(pend_atten_q))); // R5
    AST_ZC_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && pend_q && zc && !load) |=> !pend_q); // R4
    AST_HOLD_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> $stable(cur_atten_q) && $stable(cur_mute_q)); // R4
endmodule

// File: rtl/zc_scaler.sv
// Module: registered gain stage for one channel.
// Multiplies by a Q16 mantissa selected by the step position in the octave,
// then shifts right by 16 plus the octave count. Mute forces zero. The output
// register loads only on enabled (valid) cycles.
module zc_scaler
    import zc_gain_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ATTEN_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [ATTEN_W-1:0]  atten,
    input  logic                       mute,
    output logic        [SAMPLE_W-1:0] out_q
);
    localparam int PROD_W = SAMPLE_W + MANT_W + 1;

    logic [ATTEN_W-1:0]       oct, pos;
    logic [MANT_W-1:0]        mant;
    logic signed [PROD_W-1:0] prod, shifted;
    logic [SAMPLE_W-1:0]      scaled;

    // Split step count into octave shift and in-octave mantissa, then scale.
    always_comb begin
        oct     = atten / ATTEN_W'(STEPS_PER_OCT);
        pos     = atten % ATTEN_W'(STEPS_PER_OCT);
        mant    = step_mantissa(pos[3:0]);
        prod    = PROD_W'(sample) * $signed({1'b0, mant});
        shifted = prod >>> (MANT_FRAC + int'(oct));
        scaled  = mute ? '0 : shifted[SAMPLE_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (en)
            out_q <= scaled;
    end

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mute) |=> (out_q == '0)); // R7
    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mute && (atten == '0)) |=> (out_q == $past(sample))); // R3
endmodule

// File: rtl/zc_gain_ctrl.sv
// Module: top of the zero-crossing gated stereo attenuator.
// One detector, controller and scaler per channel. A single load strobe
// requests a new setting for both channels. Outputs lag in_valid by one clock.
module zc_gain_ctrl
    import zc_gain_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ATTEN_W  = 8,
    parameter int TIMEOUT  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                tgt_load,
    input  logic [ATTEN_W-1:0]  tgt_atten,
    input  logic                tgt_mute,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    logic [SAMPLE_W-1:0] ch_in  [NUM_CH];
    logic [SAMPLE_W-1:0] ch_out [NUM_CH];

    assign ch_in[0]  = in_left;
    assign ch_in[1]  = in_right;
    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic               zc;
        logic [ATTEN_W-1:0] eff_atten;
        logic               eff_mute;

        zc_detect #(.SAMPLE_W(SAMPLE_W)) u_det (
            .clk(clk), .rst_n(rst_n), .valid(in_valid),
            .sample(ch_in[c]), .zc(zc)
        );

        zc_chan_ctrl #(.ATTEN_W(ATTEN_W), .TIMEOUT(TIMEOUT)) u_ctrl (
            .clk(clk), .rst_n(rst_n), .load(tgt_load),
            .tgt_atten(tgt_atten), .tgt_mute(tgt_mute),
            .valid(in_valid), .zc(zc),
            .eff_atten(eff_atten), .eff_mute(eff_mute)
        );

        zc_scaler #(.SAMPLE_W(SAMPLE_W), .ATTEN_W(ATTEN_W)) u_scale (
            .clk(clk), .rst_n(rst_n), .en(in_valid),
            .sample($signed(ch_in[c])), .atten(eff_atten), .mute(eff_mute),
            .out_q(ch_out[c])
        );
    end

    // Output strobe follows the input strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_left) && $stable(out_right)); // R2
endmodule

// File: tb/zc_gain_ctrl_bench.sv
module zc_gain_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0, in_right = '0;
    logic        tgt_load = 1'b0;
    logic [7:0]  tgt_atten = '0;
    logic        tgt_mute = 1'b0;
    logic        out_valid;
    logic [15:0] out_left, out_right;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state, one entry per channel.
    int m_att[2];
    bit m_mute[2];
    bit m_pend[2];
    int m_patt[2];
    bit m_pmute[2];
    int m_cnt[2];
    bit m_prevneg[2];

    always #10 clk = ~clk;

    zc_gain_ctrl u_zc_gain_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .tgt_load(tgt_load), .tgt_atten(tgt_atten), .tgt_mute(tgt_mute),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic longint mant_of(int k);
        case (k)
            0: return 65536;   1: return 61870;   2: return 58409;
            3: return 55142;   4: return 52057;   5: return 49145;
            6: return 46396;   7: return 43801;   8: return 41350;
            9: return 39037;  10: return 36854;  default: return 34792;
        endcase
    endfunction

    function automatic logic [15:0] exp_scale(logic [15:0] s, int att, bit mute);
        longint p, r;
        if (mute) return 16'h0000;
        p = longint'($signed(s)) * mant_of(att % 12);
        r = p >>> (16 + att / 12);
        return r[15:0];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_att[c] = 0; m_mute[c] = 0; m_pend[c] = 0; m_patt[c] = 0;
            m_pmute[c] = 0; m_cnt[c] = 0; m_prevneg[c] = 0;
        end
    endtask

    task automatic do_load(int att, bit mute);
        @(negedge clk);
        tgt_load = 1'b1; tgt_atten = 8'(att); tgt_mute = mute;
        for (int c = 0; c < 2; c++) begin
            m_pend[c] = 1; m_patt[c] = att; m_pmute[c] = mute; m_cnt[c] = 0;
        end
        @(negedge clk);
        tgt_load = 1'b0;
    endtask

    // Advance one channel of the model by one sample; return expected output.
    function automatic logic [15:0] model_step(int c, logic [15:0] s);
        bit zc;
        zc = (s[15] != m_prevneg[c]) || (s == 16'h0000);
        if (m_pend[c]) begin
            if (zc || m_cnt[c] == 1023) begin
                m_att[c] = m_patt[c]; m_mute[c] = m_pmute[c]; m_pend[c] = 0; m_cnt[c] = 0;
            end else begin
                m_cnt[c]++;
            end
        end
        m_prevneg[c] = s[15];
        return exp_scale(s, m_att[c], m_mute[c]);
    endfunction

    task automatic do_sample(logic [15:0] l, logic [15:0] r, string tag);
        logic [15:0] el, er;
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        el = model_step(0, l);
        er = model_step(1, r);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 32'(out_valid), 32'd1);
        check({tag, " left"},  32'(out_left),  32'(el));
        check({tag, " right"}, 32'(out_right), 32'(er));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] l, r;
        bit neg_l, neg_r;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_left", 32'(out_left), 32'd0);
        check("R1 out_right", 32'(out_right), 32'd0);
        do_sample(16'd1234, 16'hF000, "R1 unity pass");
        @(negedge clk);
        // R2: no strobe, no output strobe
        check("R2 idle", 32'(out_valid), 32'd0);

        // R4: held while sign stays the same, applied at sign change
        do_sample(16'd1000, 16'd1000, "R4 pre");
        do_load(12, 0);
        for (int i = 0; i < 5; i++) do_sample(16'd2000, 16'd3000, "R4 hold");
        do_sample(16'hF830, 16'hF000, "R4 crossing");
        // R4: exact zero sample is a crossing
        do_load(7, 0);
        do_sample(16'hF000, 16'hE000, "R4 hold neg");
        do_sample(16'h0000, 16'h0000, "R4 zero");
        do_sample(16'd5000, 16'd7000, "R3 step7");

        // R5: timeout at exactly the 1024th sample
        do_load(30, 0);
        for (int i = 0; i < 1023; i++) do_sample(16'd4000, 16'd4000, "R5 wait");
        do_sample(16'd4000, 16'd4000, "R5 timeout");
        do_sample(16'd4000, 16'd4000, "R5 after");

        // R6: reload mid-wait restarts count
        do_load(3, 0);
        for (int i = 0; i < 500; i++) do_sample(16'd900, 16'd900, "R6 first wait");
        do_load(40, 0);
        for (int i = 0; i < 1023; i++) do_sample(16'd900, 16'd900, "R6 restarted");
        do_sample(16'd900, 16'd900, "R6 timeout");

        // R8: only left crosses
        do_load(24, 0);
        do_sample(16'hFF00, 16'd800, "R8 left only");
        do_sample(16'hFF00, 16'd800, "R8 right still held");
        do_sample(16'hFF00, 16'hFF00, "R8 right crosses");

        // R7: mute and unmute through deferral
        do_load(24, 1);
        do_sample(16'hFF00, 16'hFF00, "R7 mute held");
        do_sample(16'd300, 16'd300, "R7 muted");
        do_load(5, 0);
        do_sample(16'd300, 16'd300, "R7 unmute held");
        do_sample(16'hFFF0, 16'hFFF0, "R7 unmuted");

        // Random phase: runs of one sign, occasional loads.
        neg_l = 0; neg_r = 0;
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(15) == 0)
                do_load(int'($urandom_range(255)), $urandom_range(7) == 0);
            if ($urandom_range(7) == 0) neg_l = ~neg_l;
            if ($urandom_range(9) == 0) neg_r = ~neg_r;
            l = 16'($urandom_range(32767));
            r = 16'($urandom_range(32767));
            if (neg_l) l = ~l;
            if (neg_r) r = ~r;
            if ($urandom_range(63) == 0) l = 16'h0000;
            do_sample(l, r, "R3 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule